// File: doc/BRIEF.md
# Big-Endian Load/Store Byte-Lane Unit

This block sits between a 32-bit processor core and a data memory that is one word wide. For each memory request it adds a sign-extended 16-bit displacement to a base register value, turns the resulting byte address into a word address and a set of byte-lane strobes, and places the store data onto the lanes that are written. The lane mapping is big-endian: the byte with the lowest address in a word lives in the most significant lane.

On loads, the memory returns the whole word one cycle later. The unit keeps the access size, signedness and lane offset in registers and uses them to pick out the addressed byte or halfword and widen it to 32 bits, either sign-extending or zero-filling it. Accesses that are not aligned to their own size are blocked. They drive no strobes and are reported on an error output in the following cycle.

Top module: `be_lsu_lane`

## Requirements
- R1: The effective byte address is `base_addr` plus `offset` sign-extended to 32 bits, and `mem_word_addr` shows bits 31:2 of that sum in the same cycle as the request.
- R2: The size codes are 00 byte, 01 halfword, 10 word and 11 reserved. For a legal request the strobes follow big-endian lanes: a byte at offset k sets `mem_byte_en` bit 3-k, a halfword at offset 0 gives 1100, a halfword at offset 2 gives 0011, and a word gives 1111. `mem_byte_en` is 0000 whenever `req_valid` is low.
- R3: On a legal store, `mem_write` is high in the request cycle. `mem_wdata` carries `store_data[7:0]` copied into all four lanes for a byte, `store_data[15:0]` copied into both halves for a halfword, and `store_data` unchanged for a word. Bytes of the memory word outside the strobes keep their contents.
- R4: A request is misaligned when it is a halfword at an odd address, a word at an address that is not a multiple of 4, or uses size code 11. Such a request drives `mem_byte_en` to 0000 and `mem_write` low. `misalign_err` is then high in the following cycle only, and it is low after a legal request or an idle cycle.
- R5: `load_valid` is high for exactly the one cycle after a legal load request. It stays low after stores, misaligned requests and idle cycles.
- R6: Signed byte and halfword loads copy bit 7 or bit 15 of the extracted value into all higher bits of `load_data`.
- R7: Unsigned byte and halfword loads fill the higher bits of `load_data` with zeros.
- R8: A byte at offset k is taken from returned bits 31-8k down to 24-8k. A halfword at offset 0 comes from bits 31:16, a halfword at offset 2 from bits 15:0, and a word load returns `mem_rdata` whole.
- R9: After reset, with no request pending, `load_valid`, `misalign_err`, `mem_write` and `mem_byte_en` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 for a store, 0 for a load |
| req_size | input | 2 | Access size code (00 byte, 01 halfword, 10 word, 11 reserved) |
| req_signed | input | 1 | Sign-extend a narrow load |
| base_addr | input | 32 | Base register value |
| offset | input | 16 | Signed displacement |
| store_data | input | 32 | Source register value for stores |
| mem_word_addr | output | 30 | Word address to memory |
| mem_byte_en | output | 4 | Byte-lane strobes, bit 3 holds the lowest address |
| mem_write | output | 1 | Write command to memory |
| mem_wdata | output | 32 | Lane-placed store data |
| mem_rdata | input | 32 | Word returned by memory one cycle after the request |
| load_data | output | 32 | Extracted and extended load result |
| load_valid | output | 1 | `load_data` is valid this cycle |
| misalign_err | output | 1 | The previous request was misaligned |

## Verification
The address, strobes, write command and lane-placed write data are combinational. The bench samples them one time step after driving the request, while the request is still held and before the clock edge. Load data, `load_valid` and `misalign_err` come out of registers loaded at the edge that ends the request cycle. The bench samples them at the following falling edge, which is one clock after the request. In the same window it checks that the error flag and the valid pulse fall again after an idle cycle. The bench memory model returns the addressed word at that same edge, so load results line up with the request that produced them.

// File: rtl/be_lsu_pkg.sv
package be_lsu_pkg;

   typedef enum logic [1:0] {
      ACC_BYTE = 2'b00,
      ACC_HALF = 2'b01,
      ACC_WORD = 2'b10,
      ACC_RSVD = 2'b11
   } acc_size_e;

endpackage

// File: rtl/be_lsu_agen.sv
module be_lsu_agen
   import be_lsu_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int OFS_W  = 16,
   parameter int LANE_W = 2
) (
   input  logic [ADDR_W-1:0] base_i,
   input  logic [OFS_W-1:0]  ofs_i,
   input  acc_size_e         size_i,
   output logic [ADDR_W-1:0] ea_o,
   output logic              misaligned_o
);

   localparam int EXT_W = ADDR_W - OFS_W;

   assign ea_o = base_i + {{EXT_W{ofs_i[OFS_W-1]}}, ofs_i};

   always_comb begin
      unique case (size_i)
         ACC_BYTE: misaligned_o = 1'b0;
         ACC_HALF: misaligned_o = ea_o[0];
         ACC_WORD: misaligned_o = |ea_o[LANE_W-1:0];
         default:  misaligned_o = 1'b1;
      endcase
   end

endmodule

// File: rtl/be_lsu_lane_sel.sv
module be_lsu_lane_sel
   import be_lsu_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int NL     = DATA_W / 8,
   parameter int LANE_W = $clog2(NL)
) (
   input  logic              en_i,
   input  logic [LANE_W-1:0] off_i,
   input  acc_size_e         size_i,
   input  logic [DATA_W-1:0] sdata_i,
   output logic [NL-1:0]     be_o,
   output logic [DATA_W-1:0] wdata_o
);

   localparam int HALF_W = DATA_W / 2;

   logic [LANE_W:0] nbytes;
   logic [LANE_W:0] first;
   logic [LANE_W:0] last_excl;

   always_comb begin
      unique case (size_i)
         ACC_BYTE: nbytes = (LANE_W+1)'(1);
         ACC_HALF: nbytes = (LANE_W+1)'(2);
         default:  nbytes = (LANE_W+1)'(NL);
      endcase
   end

   assign first     = {1'b0, off_i};
   assign last_excl = first + nbytes;

   // Byte offset L sits in strobe bit NL-1-L (big-endian lanes).
   for (genvar L = 0; L < NL; L++) begin : g_lane
      localparam logic [LANE_W:0] LIDX = (LANE_W+1)'(L);
      assign be_o[NL-1-L] = en_i && (LIDX >= first) && (LIDX < last_excl);
   end

   always_comb begin
      unique case (size_i)
         ACC_BYTE: wdata_o = {NL{sdata_i[7:0]}};
         ACC_HALF: wdata_o = {2{sdata_i[HALF_W-1:0]}};
         default:  wdata_o = sdata_i;
      endcase
   end

endmodule

// File: rtl/be_lsu_load_align.sv
module be_lsu_load_align
   import be_lsu_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int NL     = DATA_W / 8,
   parameter int LANE_W = $clog2(NL)
) (
   input  logic [DATA_W-1:0] rdata_i,
   input  logic [LANE_W-1:0] off_i,
   input  acc_size_e         size_i,
   input  logic              signed_i,
   output logic [DATA_W-1:0] data_o
);

   localparam int HALF_W = DATA_W / 2;
   localparam int SH_W   = LANE_W + 3;

   logic [LANE_W-1:0] rev;
   logic [SH_W-1:0]   sh_byte;
   logic [SH_W-1:0]   sh_half;
   logic [DATA_W-1:0] by_byte;
   logic [DATA_W-1:0] by_half;
   logic [7:0]        b_val;
   logic [HALF_W-1:0] h_val;

   // Lowest address is the most significant lane, so shift by the reversed offset.
   assign rev     = ~off_i;
   assign sh_byte = {rev, 3'b000};
   assign sh_half = {rev[LANE_W-1:1], 1'b0, 3'b000};
   assign by_byte = rdata_i >> sh_byte;
   assign by_half = rdata_i >> sh_half;
   assign b_val   = by_byte[7:0];
   assign h_val   = by_half[HALF_W-1:0];

   always_comb begin
      unique case (size_i)
         ACC_BYTE: data_o = {{(DATA_W-8){signed_i & b_val[7]}}, b_val};
         ACC_HALF: data_o = {{(DATA_W-HALF_W){signed_i & h_val[HALF_W-1]}}, h_val};
         default:  data_o = rdata_i;
      endcase
   end

endmodule

// File: rtl/be_lsu_lane.sv
module be_lsu_lane
   import be_lsu_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 32,
   parameter int OFS_W   = 16,
   parameter int NL      = DATA_W / 8,
   parameter int LANE_W  = $clog2(NL),
   parameter int WADDR_W = ADDR_W - LANE_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic               req_write,
   input  logic [1:0]         req_size,
   input  logic               req_signed,
   input  logic [ADDR_W-1:0]  base_addr,
   input  logic [OFS_W-1:0]   offset,
   input  logic [DATA_W-1:0]  store_data,
   output logic [WADDR_W-1:0] mem_word_addr,
   output logic [NL-1:0]      mem_byte_en,
   output logic               mem_write,
   output logic [DATA_W-1:0]  mem_wdata,
   input  logic [DATA_W-1:0]  mem_rdata,
   output logic [DATA_W-1:0]  load_data,
   output logic               load_valid,
   output logic               misalign_err
);

   if (DATA_W != 32) begin : g_bad_data_w
      $error("be_lsu_lane: DATA_W must be 32 (byte, halfword and word sizes)");
   end
   if (OFS_W > ADDR_W || OFS_W < 1) begin : g_bad_ofs_w
      $error("be_lsu_lane: OFS_W must lie between 1 and ADDR_W");
   end

   acc_size_e         size_e;
   logic [ADDR_W-1:0] ea;
   logic              misaligned;
   logic              legal;

   acc_size_e         size_q;
   logic              signed_q;
   logic [LANE_W-1:0] off_q;
   logic              vld_q;
   logic              err_q;

   assign size_e = acc_size_e'(req_size);

   be_lsu_agen #(
      .ADDR_W (ADDR_W),
      .OFS_W  (OFS_W),
      .LANE_W (LANE_W)
   ) u_agen (
      .base_i       (base_addr),
      .ofs_i        (offset),
      .size_i       (size_e),
      .ea_o         (ea),
      .misaligned_o (misaligned)
   );

   assign legal         = req_valid & ~misaligned;
   assign mem_word_addr = ea[ADDR_W-1:LANE_W];
   assign mem_write     = legal & req_write;

   be_lsu_lane_sel #(
      .DATA_W (DATA_W),
      .NL     (NL),
      .LANE_W (LANE_W)
   ) u_lane_sel (
      .en_i    (legal),
      .off_i   (ea[LANE_W-1:0]),
      .size_i  (size_e),
      .sdata_i (store_data),
      .be_o    (mem_byte_en),
      .wdata_o (mem_wdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q    <= 1'b0;
         err_q    <= 1'b0;
         size_q   <= ACC_WORD;
         signed_q <= 1'b0;
         off_q    <= '0;
      end else begin
         vld_q <= legal & ~req_write;
         err_q <= req_valid & misaligned;
         if (legal && !req_write) begin
            size_q   <= size_e;
            signed_q <= req_signed;
            off_q    <= ea[LANE_W-1:0];
         end
      end
   end

   be_lsu_load_align #(
      .DATA_W (DATA_W),
      .NL     (NL),
      .LANE_W (LANE_W)
   ) u_load_align (
      .rdata_i  (mem_rdata),
      .off_i    (off_q),
      .size_i   (size_q),
      .signed_i (signed_q),
      .data_o   (load_data)
   );

   assign load_valid   = vld_q;
   assign misalign_err = err_q;

endmodule

// File: rtl/be_lsu_lane_chk.sv
module be_lsu_lane_chk #(
   parameter int DATA_W = 32,
   parameter int NL     = DATA_W / 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic [1:0]        req_size,
   input logic              req_signed,
   input logic [NL-1:0]     mem_byte_en,
   input logic              mem_write,
   input logic [DATA_W-1:0] load_data,
   input logic              load_valid,
   input logic              misalign_err
);

   a_r2_idle_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> mem_byte_en == '0);

   a_r2_byte_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_size == 2'b00) |-> $countones(mem_byte_en) <= 1);

   a_r3_write_needs_store: assert property (@(posedge clk) disable iff (!rst_n)
      mem_write |-> (req_valid && req_write && mem_byte_en != '0));

   a_r4_err_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      misalign_err |-> $past(req_valid));

   a_r4_rsvd_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_size == 2'b11) |-> (mem_byte_en == '0 && !mem_write));

   a_r5_valid_follows_load: assert property (@(posedge clk) disable iff (!rst_n)
      load_valid |-> $past(req_valid && !req_write));

   a_r5_err_excl_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !(load_valid && misalign_err));

   a_r6_signed_byte_ext: assert property (@(posedge clk) disable iff (!rst_n)
      (load_valid && $past(req_size == 2'b00 && req_signed))
      |-> load_data[DATA_W-1:8] == {(DATA_W-8){load_data[7]}});

   a_r7_unsigned_byte_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (load_valid && $past(req_size == 2'b00 && !req_signed))
      |-> load_data[DATA_W-1:8] == '0);

endmodule

bind be_lsu_lane be_lsu_lane_chk #(
   .DATA_W (DATA_W),
   .NL     (NL)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_write    (req_write),
   .req_size     (req_size),
   .req_signed   (req_signed),
   .mem_byte_en  (mem_byte_en),
   .mem_write    (mem_write),
   .load_data    (load_data),
   .load_valid   (load_valid),
   .misalign_err (misalign_err)
);

// File: tb/be_lsu_lane_tb_top.sv
module be_lsu_lane_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [1:0]  req_size = 2'b00;
   logic        req_signed = 1'b0;
   logic [31:0] base_addr = '0;
   logic [15:0] offset = '0;
   logic [31:0] store_data = '0;
   logic [29:0] mem_word_addr;
   logic [3:0]  mem_byte_en;
   logic        mem_write;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata;
   logic [31:0] load_data;
   logic        load_valid;
   logic        misalign_err;

   int n_chk  = 0;
   int n_fail = 0;

   // sampled results of the last request
   logic [29:0] s_addr;
   logic [3:0]  s_be;
   logic        s_wr;
   logic [31:0] s_wdata;
   logic [31:0] s_ldata;
   logic        s_lvld;
   logic        s_err;

   always #5 clk = ~clk;

   be_lsu_lane dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_write     (req_write),
      .req_size      (req_size),
      .req_signed    (req_signed),
      .base_addr     (base_addr),
      .offset        (offset),
      .store_data    (store_data),
      .mem_word_addr (mem_word_addr),
      .mem_byte_en   (mem_byte_en),
      .mem_write     (mem_write),
      .mem_wdata     (mem_wdata),
      .mem_rdata     (mem_rdata),
      .load_data     (load_data),
      .load_valid    (load_valid),
      .misalign_err  (misalign_err)
   );

   // single-cycle memory model: 16 words
   logic [31:0] mem [16];
   always @(posedge clk) begin
      if (mem_write) begin
         for (int i = 0; i < 4; i++)
            if (mem_byte_en[i]) mem[mem_word_addr[3:0]][8*i +: 8] <= mem_wdata[8*i +: 8];
      end
      mem_rdata <= mem[mem_word_addr[3:0]];
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic issue(input logic wr, input logic [1:0] sz, input logic sg,
                        input logic [31:0] base, input logic [15:0] ofs, input logic [31:0] sd);
      @(negedge clk);
      req_valid  = 1'b1;
      req_write  = wr;
      req_size   = sz;
      req_signed = sg;
      base_addr  = base;
      offset     = ofs;
      store_data = sd;
      #1;
      s_addr  = mem_word_addr;
      s_be    = mem_byte_en;
      s_wr    = mem_write;
      s_wdata = mem_wdata;
      @(negedge clk);
      req_valid = 1'b0;
      req_write = 1'b0;
      s_ldata = load_data;
      s_lvld  = load_valid;
      s_err   = misalign_err;
   endtask

   // {base, offset, size, signed, exp strobes, exp error, exp load data}
   localparam int NV = 15;
   localparam logic [87:0] VEC [NV] = '{
      {32'h0000_0100, 16'h0000, 2'd0, 1'b1, 4'b1000, 1'b0, 32'hFFFF_FF8A},
      {32'h0000_0100, 16'h0000, 2'd0, 1'b0, 4'b1000, 1'b0, 32'h0000_008A},
      {32'h0000_0100, 16'h0001, 2'd0, 1'b1, 4'b0100, 1'b0, 32'h0000_007B},
      {32'h0000_00FE, 16'h0004, 2'd0, 1'b1, 4'b0010, 1'b0, 32'hFFFF_FFC6},
      {32'h0000_0100, 16'h0003, 2'd0, 1'b0, 4'b0001, 1'b0, 32'h0000_00D5},
      {32'h0000_0100, 16'h0000, 2'd1, 1'b1, 4'b1100, 1'b0, 32'hFFFF_8A7B},
      {32'h0000_0100, 16'h0002, 2'd1, 1'b0, 4'b0011, 1'b0, 32'h0000_C6D5},
      {32'h0000_0100, 16'h0002, 2'd1, 1'b1, 4'b0011, 1'b0, 32'hFFFF_C6D5},
      {32'h0000_0100, 16'h0000, 2'd2, 1'b0, 4'b1111, 1'b0, 32'h8A7B_C6D5},
      {32'h0000_0100, 16'h0001, 2'd1, 1'b1, 4'b0000, 1'b1, 32'h0000_0000},
      {32'h0000_0100, 16'h0002, 2'd2, 1'b0, 4'b0000, 1'b1, 32'h0000_0000},
      {32'h0000_0100, 16'h0003, 2'd2, 1'b0, 4'b0000, 1'b1, 32'h0000_0000},
      {32'h0000_0108, 16'hFFF8, 2'd0, 1'b1, 4'b1000, 1'b0, 32'hFFFF_FF8A},
      {32'h0000_0100, 16'h0000, 2'd3, 1'b0, 4'b0000, 1'b1, 32'h0000_0000},
      {32'h0000_00FC, 16'h0004, 2'd2, 1'b1, 4'b1111, 1'b0, 32'h8A7B_C6D5}
   };

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9: reset state
      check("R9 load_valid", 32'(load_valid), 32'd0);
      check("R9 misalign_err", 32'(misalign_err), 32'd0);
      check("R9 mem_byte_en", 32'(mem_byte_en), 32'd0);
      check("R9 mem_write", 32'(mem_write), 32'd0);

      // preload word at byte address 0x100
      issue(1'b1, 2'd2, 1'b0, 32'h100, 16'h0, 32'h8A7B_C6D5);
      check("R3 word strobes", 32'(s_be), 32'hF);
      check("R3 word wdata", s_wdata, 32'h8A7B_C6D5);
      check("R5 no valid after store", 32'(s_lvld), 32'd0);

      // table walk: loads (R1 R2 R4 R5 R6 R7 R8)
      for (int i = 0; i < NV; i++) begin
         logic [31:0] vb;
         logic [15:0] vo;
         logic [1:0]  vs;
         logic        vg;
         logic [3:0]  ebe;
         logic        eerr;
         logic [31:0] ed;
         logic [31:0] ea;
         {vb, vo, vs, vg, ebe, eerr, ed} = VEC[i];
         ea = vb + {{16{vo[15]}}, vo};
         issue(1'b0, vs, vg, vb, vo, 32'h0);
         check($sformatf("R2 strobes vec%0d", i), 32'(s_be), 32'(ebe));
         check($sformatf("R4 error vec%0d", i), 32'(s_err), 32'(eerr));
         check($sformatf("R5 valid vec%0d", i), 32'(s_lvld), 32'(!eerr));
         if (!eerr) begin
            check($sformatf("R1 word addr vec%0d", i), 32'(s_addr), 32'(ea[31:2]));
            check($sformatf("R6 R7 R8 load data vec%0d", i), s_ldata, ed);
         end
      end

      // R3: byte store lands in one lane, others kept
      issue(1'b1, 2'd0, 1'b0, 32'h100, 16'h1, 32'h1234_56EE);
      check("R3 byte strobes", 32'(s_be), 32'h4);
      check("R3 byte wdata", s_wdata, 32'hEEEE_EEEE);
      check("R3 byte write", 32'(s_wr), 32'd1);
      issue(1'b0, 2'd2, 1'b0, 32'h100, 16'h0, 32'h0);
      check("R3 byte store result", s_ldata, 32'h8AEE_C6D5);

      // R3: halfword store
      issue(1'b1, 2'd1, 1'b0, 32'h100, 16'h2, 32'hCAFE_BEEF);
      check("R3 half strobes", 32'(s_be), 32'h3);
      check("R3 half wdata", s_wdata, 32'hBEEF_BEEF);
      issue(1'b0, 2'd2, 1'b0, 32'h100, 16'h0, 32'h0);
      check("R3 half store result", s_ldata, 32'h8AEE_BEEF);

      // R4: misaligned store is dropped
      issue(1'b1, 2'd1, 1'b0, 32'h100, 16'h3, 32'h0000_1111);
      check("R4 misaligned strobes", 32'(s_be), 32'h0);
      check("R4 misaligned write", 32'(s_wr), 32'd0);
      check("R4 misaligned error", 32'(s_err), 32'd1);
      @(negedge clk);
      check("R4 error one cycle", 32'(misalign_err), 32'd0);
      check("R5 no valid when idle", 32'(load_valid), 32'd0);
      issue(1'b0, 2'd2, 1'b0, 32'h100, 16'h0, 32'h0);
      check("R4 memory untouched", s_ldata, 32'h8AEE_BEEF);
      check("R4 no error after legal", 32'(s_err), 32'd0);

      // R8: byte at offset 3 of another word
      issue(1'b1, 2'd2, 1'b0, 32'h104, 16'h0, 32'h0102_0304);
      check("R1 word addr second word", 32'(s_addr), 32'h41);
      issue(1'b0, 2'd0, 1'b1, 32'h104, 16'h3, 32'h0);
      check("R8 last lane byte", s_ldata, 32'h0000_0004);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule